// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Unit

This unit watches a processor's instruction fetches and data accesses against four programmable linear addresses. Each slot has its own match kind and watched length, set through a control word. When a slot matches, or when the core reports a single-step, a trap-flagged task entry or a pending debug-register access, the unit raises a one-cycle debug request. It also leaves a sticky record of the causes in a status word.

Software programs the slots through a small register port. Reads are combinational, and writes take effect at the next rising clock edge. A task-switch pulse drops the per-task (local) enables and keeps the persistent (global) ones. The debug handler can then see which slots fired across several switches.

Top module: `hw_bkpt_unit`

## Requirements
- R1: After reset, every register reads 0 and `dbg_req` is low.
- R2: The register port has this map:
  - `reg_addr` 0-3 select the slot addresses.
  - 4 selects the status word.
  - 5 selects the control word.
  - 6 and 7 read 0 and ignore writes.
  - A status write keeps only bits 0-3 and 13-15.
- R3: Slot n is armed when control bit 2n (local) or bit 2n+1 (global) is set. An unarmed slot never matches.
- R4: Slot n's match kind sits in control bits 16+4n..17+4n. Kind 00 matches a valid fetch whose address equals the slot address exactly. It ignores the length field and all data accesses.
- R5: Kind 01 matches data writes only. Kind 11 matches data reads and writes. Kind 10 never matches.
- R6: Slot n's length code sits in control bits 18+4n..19+4n: 00 = 1, 01 = 2, 11 = 4 and 10 = 8 bytes. The slot address is aligned down to that length. A data access of 2^`data_size` bytes matches when its byte range overlaps the watched range.
- R7: A `task_sw` pulse clears control bits 0, 2, 4 and 6 and leaves bits 1, 3, 5 and 7 unchanged. A control write in the same cycle is applied first and then has those bits cleared.
- R8: Status bit n is set when slot n matches. Status bits are sticky until a status write. A status write in the same cycle as a new cause keeps that cause's bit.
- R9: Status bit 14 records `single_step`, bit 15 records `task_trap` and bit 13 records `dbg_access`.
- R10: `dbg_req` is high for exactly the one cycle after any cycle that has a slot match or an event input. The new status is readable in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_vld | input | 1 | Instruction fetch valid |
| fetch_addr | input | ADDR_W | Fetch linear address |
| data_vld | input | 1 | Data access valid |
| data_addr | input | ADDR_W | Data access start address |
| data_size | input | 2 | Access length code, 2^code bytes |
| data_wr | input | 1 | 1 = write, 0 = read |
| task_sw | input | 1 | Hardware task switch pulse |
| single_step | input | 1 | Single-step event |
| task_trap | input | 1 | Entry into a trap-flagged task |
| dbg_access | input | 1 | Next instruction touches a debug register |
| dbg_req | output | 1 | Debug exception request pulse |

## Verification
Every state change lands at the rising edge after the cycle that carries its cause. Both `dbg_req` and the status word therefore show a match one edge after the fetch or access that produced it. `reg_rdata` depends only on `reg_addr` and the registered state. The bench drives each stimulus on a falling edge and compares `reg_rdata` in that same half cycle against a model of the state before the edge. It then checks `dbg_req` at the next falling edge against the request the model derived from that stimulus. Directed cases follow each cause with a read on the very next cycle, so a request or status update that arrives a cycle late, or lasts longer than one cycle, shows up as a mismatch.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int NUM_BP = 4;
    localparam int REG_W  = 32;
    localparam int RA_W   = 3;

    localparam logic [RA_W-1:0] RA_STAT = 3'd4;
    localparam logic [RA_W-1:0] RA_CTRL = 3'd5;

    localparam int ST_ACCESS = 13;
    localparam int ST_STEP   = 14;
    localparam int ST_TRAP   = 15;
    localparam logic [REG_W-1:0] STAT_MASK = 32'h0000_E00F;

    localparam int FLD_BASE = 16;
    localparam int FLD_STEP = 4;

    typedef enum logic [1:0] {
        KIND_EXEC = 2'b00,
        KIND_WR   = 2'b01,
        KIND_IO   = 2'b10,
        KIND_RW   = 2'b11
    } kind_e;

    // watched length minus one, from the slot length code
    function automatic logic [2:0] watch_span(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd0;
            2'b01:   return 3'd1;
            2'b11:   return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    // access length minus one, 2^code bytes
    function automatic logic [2:0] access_span(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd0;
            2'b01:   return 3'd1;
            2'b10:   return 3'd3;
            default: return 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic              armed,
    input  logic [1:0]        kind,
    input  logic [1:0]        len_code,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_vld,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [1:0]        data_size,
    input  logic              data_wr,
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [ADDR_W-1:0] span_w;
    logic [ADDR_W-1:0] base;
    logic [EXT_W-1:0]  w_lo;
    logic [EXT_W-1:0]  w_hi;
    logic [EXT_W-1:0]  a_lo;
    logic [EXT_W-1:0]  a_hi;
    logic              overlap;
    logic              exec_m;

    always_comb begin
        span_w  = ADDR_W'(watch_span(len_code));
        base    = bp_addr & ~span_w;
        w_lo    = {1'b0, base};
        w_hi    = w_lo + EXT_W'(span_w);
        a_lo    = {1'b0, data_addr};
        a_hi    = a_lo + EXT_W'(access_span(data_size));
        overlap = (a_lo <= w_hi) && (w_lo <= a_hi);
        exec_m  = fetch_vld && (fetch_addr == bp_addr);
        case (kind_e'(kind))
            KIND_EXEC: hit = armed && exec_m;
            KIND_WR:   hit = armed && data_vld && data_wr && overlap;
            KIND_RW:   hit = armed && data_vld && overlap;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bkpt_evt.sv
module bkpt_evt
    import bkpt_pkg::*;
(
    input  logic [NUM_BP-1:0] hits,
    input  logic              single_step,
    input  logic              task_trap,
    input  logic              dbg_access,
    output logic [REG_W-1:0]  evt_bits,
    output logic              evt_any
);
    always_comb begin
        evt_bits               = '0;
        evt_bits[NUM_BP-1:0]   = hits;
        evt_bits[ST_ACCESS]    = dbg_access;
        evt_bits[ST_STEP]      = single_step;
        evt_bits[ST_TRAP]      = task_trap;
        evt_any                = |evt_bits;
    end
endmodule

// File: rtl/bkpt_rdmux.sv
module bkpt_rdmux
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [RA_W-1:0]                reg_addr,
    input  logic [NUM_BP-1:0][ADDR_W-1:0]  addr_q,
    input  logic [REG_W-1:0]               ctrl_q,
    input  logic [REG_W-1:0]               stat_q,
    output logic [REG_W-1:0]               reg_rdata
);
    localparam int IDX_W = $clog2(NUM_BP);

    always_comb begin
        if (reg_addr < RA_W'(NUM_BP)) begin
            reg_rdata = REG_W'(addr_q[reg_addr[IDX_W-1:0]]);
        end else if (reg_addr == RA_STAT) begin
            reg_rdata = stat_q;
        end else if (reg_addr == RA_CTRL) begin
            reg_rdata = ctrl_q;
        end else begin
            reg_rdata = '0;
        end
    end
endmodule

// File: rtl/hw_bkpt_unit.sv
module hw_bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_vld,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [1:0]        data_size,
    input  logic              data_wr,
    input  logic              task_sw,
    input  logic              single_step,
    input  logic              task_trap,
    input  logic              dbg_access,
    output logic              dbg_req
);
    localparam int IDX_W = $clog2(NUM_BP);

    typedef struct packed {
        logic [NUM_BP-1:0][ADDR_W-1:0] addr;
        logic [REG_W-1:0]              ctrl;
        logic [REG_W-1:0]              stat;
        logic                          req;
    } state_t;

    state_t s_d, s_q;

    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  stat_q;
    logic [NUM_BP-1:0] hits;
    logic [REG_W-1:0]  evt_bits;
    logic              evt_any;

    assign ctrl_q = s_q.ctrl;
    assign stat_q = s_q.stat;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
        bkpt_cmp #(.ADDR_W(ADDR_W)) i_cmp (
            .bp_addr    (s_q.addr[g]),
            .armed      (ctrl_q[2*g] | ctrl_q[2*g+1]),
            .kind       (ctrl_q[FLD_BASE + FLD_STEP*g +: 2]),
            .len_code   (ctrl_q[FLD_BASE + FLD_STEP*g + 2 +: 2]),
            .fetch_vld  (fetch_vld),
            .fetch_addr (fetch_addr),
            .data_vld   (data_vld),
            .data_addr  (data_addr),
            .data_size  (data_size),
            .data_wr    (data_wr),
            .hit        (hits[g])
        );
    end

    bkpt_evt i_evt (
        .hits        (hits),
        .single_step (single_step),
        .task_trap   (task_trap),
        .dbg_access  (dbg_access),
        .evt_bits    (evt_bits),
        .evt_any     (evt_any)
    );

    bkpt_rdmux #(.ADDR_W(ADDR_W)) i_rdmux (
        .reg_addr  (reg_addr),
        .addr_q    (s_q.addr),
        .ctrl_q    (ctrl_q),
        .stat_q    (stat_q),
        .reg_rdata (reg_rdata)
    );

    always_comb begin
        s_d = s_q;
        if (reg_we && (reg_addr < RA_W'(NUM_BP))) begin
            s_d.addr[reg_addr[IDX_W-1:0]] = reg_wdata[ADDR_W-1:0];
        end
        if (reg_we && (reg_addr == RA_CTRL)) begin
            s_d.ctrl = reg_wdata;
        end
        if (task_sw) begin
            for (int n = 0; n < NUM_BP; n++) begin
                s_d.ctrl[2*n] = 1'b0;
            end
        end
        s_d.stat = ((reg_we && (reg_addr == RA_STAT)) ? (reg_wdata & STAT_MASK) : s_q.stat)
                   | evt_bits;
        s_d.req  = evt_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dbg_req = s_q.req;
endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic        task_sw,
    input logic        single_step,
    input logic        task_trap,
    input logic        dbg_req,
    input logic [31:0] ctrl_q,
    input logic [31:0] stat_q
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_TSW_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(task_sw) |-> (ctrl_q & 32'h55) == 32'h0); // R7

    AST_TSW_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(task_sw) && !$past(reg_we && reg_addr == 3'd5)
        |-> (ctrl_q & 32'hAA) == ($past(ctrl_q) & 32'hAA)); // R7

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(reg_we && reg_addr == 3'd4)
        |-> ($past(stat_q) & ~stat_q) == 32'h0); // R8

    AST_STEP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(single_step) |-> dbg_req && stat_q[14]); // R9

    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(task_trap) |-> dbg_req && stat_q[15]); // R9

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> stat_q != 32'h0); // R10
endmodule

bind hw_bkpt_unit bkpt_chk i_bkpt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .task_sw     (task_sw),
    .single_step (single_step),
    .task_trap   (task_trap),
    .dbg_req     (dbg_req),
    .ctrl_q      (ctrl_q),
    .stat_q      (stat_q)
);

// File: tb/test_hw_bkpt_unit.sv
module test_hw_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        fetch_vld;
    logic [31:0] fetch_addr;
    logic        data_vld;
    logic [31:0] data_addr;
    logic [1:0]  data_size;
    logic        data_wr;
    logic        task_sw;
    logic        single_step;
    logic        task_trap;
    logic        dbg_access;
    logic        dbg_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [31:0] m_addr [4];
    logic [31:0] m_ctrl;
    logic [31:0] m_stat;
    logic        m_req;

    always #5 clk = ~clk;

    hw_bkpt_unit i_hw_bkpt_unit (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .fetch_vld, .fetch_addr, .data_vld, .data_addr, .data_size, .data_wr,
        .task_sw, .single_step, .task_trap, .dbg_access, .dbg_req
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R2 register map
    function automatic logic [31:0] m_read(input logic [2:0] ra);
        if (ra < 3'd4)       return m_addr[ra[1:0]];
        else if (ra == 3'd4) return m_stat;
        else if (ra == 3'd5) return m_ctrl;
        else                 return 32'h0;
    endfunction

    // R3..R6 slot matching
    function automatic logic [3:0] m_hits();
        logic [3:0] h = '0;
        for (int n = 0; n < 4; n++) begin
            logic        en    = m_ctrl[2*n] | m_ctrl[2*n+1];
            logic [1:0]  kind  = m_ctrl[16+4*n +: 2];
            logic [1:0]  lc    = m_ctrl[18+4*n +: 2];
            longint      len   = (lc == 2'b00) ? 1 : (lc == 2'b01) ? 2 : (lc == 2'b11) ? 4 : 8;
            longint      base  = longint'(m_addr[n]) & ~(len - 1);
            longint      alo   = longint'(data_addr);
            longint      ahi   = alo + (longint'(1) << data_size) - 1;
            logic        ovl   = (alo <= base + len - 1) && (base <= ahi);
            if (en) begin
                if (kind == 2'b00)      h[n] = fetch_vld && (fetch_addr == m_addr[n]);
                else if (kind == 2'b01) h[n] = data_vld && data_wr && ovl;
                else if (kind == 2'b11) h[n] = data_vld && ovl;
            end
        end
        return h;
    endfunction

    task automatic idle_in();
        reg_we = 0; reg_addr = 0; reg_wdata = 0;
        fetch_vld = 0; fetch_addr = 0; data_vld = 0; data_addr = 0;
        data_size = 0; data_wr = 0; task_sw = 0; single_step = 0;
        task_trap = 0; dbg_access = 0;
    endtask

    // one cycle: inputs already driven at a falling edge
    task automatic cycle();
        logic [31:0] ev;
        #1;
        chk(reg_rdata, m_read(reg_addr), "R2 read data");
        ev = {16'h0, task_trap, single_step, dbg_access, 9'h0, m_hits()};
        if (reg_we && reg_addr < 3'd4) m_addr[reg_addr[1:0]] = reg_wdata;
        if (reg_we && reg_addr == 3'd5) m_ctrl = reg_wdata;
        if (task_sw) m_ctrl = m_ctrl & ~32'h55;
        m_stat = ((reg_we && reg_addr == 3'd4) ? (reg_wdata & 32'h0000_E00F) : m_stat) | ev;
        m_req  = (ev != 0);
        @(negedge clk);
        chk({31'h0, dbg_req}, {31'h0, m_req}, "R10 request pulse");
    endtask

    task automatic wr(input logic [2:0] ra, input logic [31:0] wd);
        idle_in(); reg_we = 1; reg_addr = ra; reg_wdata = wd; cycle();
    endtask

    task automatic rd_chk(input logic [2:0] ra, input logic [31:0] exp, input string tag);
        idle_in(); reg_addr = ra; #1; chk(reg_rdata, exp, tag); cycle();
    endtask

    task automatic fetch(input logic [31:0] a);
        idle_in(); fetch_vld = 1; fetch_addr = a; cycle();
    endtask

    task automatic dacc(input logic [31:0] a, input logic [1:0] sz, input logic w);
        idle_in(); data_vld = 1; data_addr = a; data_size = sz; data_wr = w; cycle();
    endtask

    task automatic req_chk(input logic exp, input string tag);
        chk({31'h0, dbg_req}, {31'h0, exp}, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_in();
        rst_n = 0;
        for (int i = 0; i < 4; i++) m_addr[i] = 0;
        m_ctrl = 0; m_stat = 0; m_req = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int ra = 0; ra < 8; ra++) begin
            reg_addr = 3'(ra); #1;
            chk(reg_rdata, 32'h0, "R1 reset register");
        end
        chk({31'h0, dbg_req}, 32'h0, "R1 reset request");
        rst_n = 1;
        @(negedge clk);

        // R2 map, unmapped slots, status mask
        wr(0, 32'h1234_5678); wr(6, 32'hFFFF_FFFF);
        rd_chk(0, 32'h1234_5678, "R2 slot address");
        rd_chk(6, 32'h0, "R2 unmapped read");
        rd_chk(7, 32'h0, "R2 unmapped read");
        wr(4, 32'hFFFF_FFFF);
        rd_chk(4, 32'h0000_E00F, "R2 status mask");
        wr(4, 0);

        // R4 execution kind
        wr(0, 32'h2000); wr(5, 32'h1);
        fetch(32'h2000); req_chk(1, "R4 exec hit");
        rd_chk(4, 32'h1, "R4 status bit0");
        wr(4, 0);
        fetch(32'h2001); req_chk(0, "R4 exec exact");
        wr(5, 32'h000C_0001);
        fetch(32'h2001); req_chk(0, "R4 exec ignores length");
        dacc(32'h2000, 0, 1); req_chk(0, "R4 exec ignores data");
        fetch(32'h2000); req_chk(1, "R4 exec hit with length");
        wr(4, 0);

        // R5 data kinds
        wr(1, 32'h3000); wr(5, 32'h0010_0008);
        dacc(32'h3000, 0, 0); req_chk(0, "R5 write-only ignores read");
        dacc(32'h3000, 0, 1); req_chk(1, "R5 write-only hit");
        rd_chk(4, 32'h2, "R5 status bit1");
        wr(4, 0);
        wr(5, 32'h0030_0008);
        dacc(32'h3000, 0, 0); req_chk(1, "R5 read/write hit on read");
        wr(5, 32'h0020_0008);
        dacc(32'h3000, 0, 1); req_chk(0, "R5 reserved kind write");
        fetch(32'h3000); req_chk(0, "R5 reserved kind fetch");
        wr(4, 0);

        // R3 arming
        wr(5, 32'h0030_0000);
        dacc(32'h3000, 0, 1); req_chk(0, "R3 unarmed");
        wr(5, 32'h0030_0004);
        dacc(32'h3000, 0, 1); req_chk(1, "R3 local enable arms");
        wr(4, 0);

        // R6 lengths and overlap
        wr(2, 32'h4005); wr(5, 32'h0F00_0010);
        dacc(32'h4002, 2'b01, 0); req_chk(0, "R6 4-byte below");
        dacc(32'h4003, 2'b01, 0); req_chk(1, "R6 4-byte overlap low");
        dacc(32'h4008, 2'b00, 0); req_chk(0, "R6 4-byte above");
        dacc(32'h4001, 2'b11, 0); req_chk(1, "R6 8-byte access spans");
        wr(5, 32'h0B00_0010);
        dacc(32'h4000, 2'b00, 0); req_chk(1, "R6 8-byte base");
        dacc(32'h4007, 2'b00, 0); req_chk(1, "R6 8-byte top");
        dacc(32'h4008, 2'b00, 0); req_chk(0, "R6 8-byte past end");
        wr(5, 32'h0300_0010);
        dacc(32'h4004, 2'b00, 0); req_chk(0, "R6 1-byte miss");
        dacc(32'h4004, 2'b01, 0); req_chk(1, "R6 1-byte overlap");
        rd_chk(4, 32'h4, "R6 status bit2");
        wr(4, 0);

        // R7 task switch
        wr(5, 32'h0000_00FF);
        idle_in(); task_sw = 1; cycle();
        rd_chk(5, 32'h0000_00AA, "R7 locals cleared globals kept");
        idle_in(); reg_we = 1; reg_addr = 5; reg_wdata = 32'h55; task_sw = 1; cycle();
        rd_chk(5, 32'h0, "R7 write then clear");

        // R8 sticky accumulation
        wr(5, 32'h0010_000A);
        fetch(32'h2000); dacc(32'h3000, 0, 1);
        rd_chk(4, 32'h3, "R8 accumulate");
        rd_chk(4, 32'h3, "R8 sticky");
        idle_in(); reg_we = 1; reg_addr = 4; reg_wdata = 0;
        fetch_vld = 1; fetch_addr = 32'h2000; cycle();
        rd_chk(4, 32'h1, "R8 write with new cause");
        wr(4, 0);
        rd_chk(4, 32'h0, "R8 cleared");

        // R9 event causes, R10 pulse width
        idle_in(); single_step = 1; cycle(); req_chk(1, "R10 step pulse");
        rd_chk(4, 32'h4000, "R9 step bit");
        req_chk(0, "R10 one cycle only");
        wr(4, 0);
        idle_in(); task_trap = 1; cycle();
        rd_chk(4, 32'h8000, "R9 trap bit");
        wr(4, 0);
        idle_in(); dbg_access = 1; cycle();
        rd_chk(4, 32'h2000, "R9 access bit");
        wr(4, 0);

        // random mix, checked by model each cycle (R2, R10)
        for (int i = 0; i < 4000; i++) begin
            idle_in();
            reg_we      = ($urandom % 8) == 0;
            reg_addr    = 3'($urandom % 8);
            reg_wdata   = (reg_addr < 3'd4) ? 32'h1000 + ($urandom % 64) : $urandom;
            fetch_vld   = $urandom % 2;
            fetch_addr  = 32'h1000 + ($urandom % 64);
            data_vld    = $urandom % 2;
            data_addr   = 32'h1000 + ($urandom % 64);
            data_size   = 2'($urandom % 4);
            data_wr     = $urandom % 2;
            task_sw     = ($urandom % 16) == 0;
            single_step = ($urandom % 32) == 0;
            task_trap   = ($urandom % 32) == 0;
            dbg_access  = ($urandom % 32) == 0;
            cycle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule